// File: doc/BRIEF.md
# Serial Port Peripheral with Byte Queues

This block is a compact asynchronous serial port that sits on a simple 32-bit register bus. Software reaches it through four word registers. One register pops received bytes and one pushes bytes to send. A read-only status word shows queue levels, errors and the interrupt enable. A write-only control word empties either queue and sets the interrupt enable. Each direction has a byte queue, sixteen deep by default.

The line format is chosen when the design is built and cannot be changed at run time. Parameters set the clock divider that produces a tick at sixteen times the bit rate, the number of data bits, and whether a parity bit is present and whether it is even or odd. Only two serial pins exist, one out and one in. There is no handshake. Each frame has one start bit, the data bits least significant first, the optional parity bit and one stop bit. The receiver takes every bit at its middle. It records overrun, framing and parity faults in sticky flags. An interrupt pulse can tell software that data has arrived or that the send queue has drained.

Top module: `ser_port`

## Requirements
- R1: After reset, the status word reads 0x04 (send queue empty, all other bits clear), `irq` is low and `txd` is high.
- R2: Register decode uses byte address bits [3:0]. A read at 0x0 pops one received byte and returns it in bits [7:0]. A write at 0x4 queues bits [7:0] for sending. A read at 0x8 returns the status word. A write at 0xC is the control word. Reads at 0x4 and 0xC return zero.
- R3: A transmitted frame is a low start bit, then the data bits least significant first, then an even parity bit (the XOR of the data) and a high stop bit. Each bit lasts 16*TICK_DIV clocks. Between frames the line idles high.
- R4: The send queue accepts FIFO_DEPTH bytes and, in addition, the byte being shifted out. A write to a full send queue is dropped. Status bit 3 flags the send queue full and bit 2 flags it empty.
- R5: The receiver takes each bit at mid-bit and queues the byte when it samples the stop bit. Status bit 0 means at least one byte is queued and bit 1 means the receive queue is full. Bytes are returned in arrival order.
- R6: A byte that completes while the receive queue is full is discarded and sets status bit 5 (overrun).
- R7: A low stop bit sets status bit 6 (framing). The byte is still queued.
- R8: A parity bit that disagrees with the data sets status bit 7 (parity). The byte is still queued.
- R9: Error bits 5 to 7 stay set until a status read. That read returns them and then clears them.
- R10: Writing control bit 0 empties the send queue and writing bit 1 empties the receive queue. Neither bit is stored, so a later control write with the bit at zero leaves the queues as they are. A frame already being shifted out is finished.
- R11: Control bit 4 is stored as the interrupt enable and reads back as status bit 4.
- R12: While the enable is set, `irq` is high for exactly one clock when the receive queue goes from empty to non-empty, and for one clock when the send queue goes from non-empty to empty. With the enable clear, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address inside the register window |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt pulse |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |

## Verification
The assertions assume that software never raises both strobes in one cycle. They also assume that the serial input carries frames at the nominal bit rate and not faster. The overrun and pulse properties depend on the receiver producing at most one completed byte per frame time. The bench drives every bus access for exactly one clock from the falling edge. It builds each incoming frame to exactly 16*TICK_DIV clocks per bit. The only exception is the deliberately shortened low stop bit, which it returns high well before the receiver could mistake it for a new start bit.

// File: rtl/ser_pkg.sv
package ser_pkg;

    typedef enum logic [2:0] {
        LN_IDLE  = 3'd0,
        LN_START = 3'd1,
        LN_DATA  = 3'd2,
        LN_PAR   = 3'd3,
        LN_STOP  = 3'd4
    } line_st_e;

    // word offsets, taken from byte address bits [3:2]
    localparam logic [1:0] WRD_RXQ  = 2'd0;
    localparam logic [1:0] WRD_TXQ  = 2'd1;
    localparam logic [1:0] WRD_STAT = 2'd2;
    localparam logic [1:0] WRD_CTRL = 2'd3;

    // control bit positions
    localparam int CB_TX_FLUSH = 0;
    localparam int CB_RX_FLUSH = 1;
    localparam int CB_IEN      = 4;

    // ticks per bit
    localparam int OVS = 16;

endpackage

// File: rtl/ser_fifo.sv
module ser_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            cnt;
    } fq_t;

    fq_t  s_q, s_d;
    logic do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        do_push = push && (s_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop && (s_q.cnt != '0);
        if (clr) begin
            s_d.wr  = '0;
            s_d.rd  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wr] = din;
                s_d.wr = (s_q.wr == PTR_W'(DEPTH - 1)) ? '0 : s_q.wr + 1'b1;
            end
            if (do_pop) begin
                s_d.rd = (s_q.rd == PTR_W'(DEPTH - 1)) ? '0 : s_q.rd + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout  = s_q.mem[s_q.rd];
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CNT_W'(DEPTH));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH)); // R4
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty); // R10

endmodule

// File: rtl/ser_tx.sv
module ser_tx
    import ser_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter bit PAR_EN    = 1'b1,
    parameter bit PAR_ODD   = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 have,
    input  logic [DATA_BITS-1:0] data,
    output logic                 take,
    output logic                 txd
);
    localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    typedef struct packed {
        line_st_e             st;
        logic [3:0]           sub;
        logic [IW-1:0]        idx;
        logic [DATA_BITS-1:0] sh;
        logic                 par;
        logic                 txd;
    } tx_t;

    localparam tx_t TX_RST = '{st: LN_IDLE, sub: 4'd0, idx: '0, sh: '0,
                               par: 1'b0, txd: 1'b1};

    tx_t s_q, s_d;
    logic bit_end;

    always_comb begin
        s_d     = s_q;
        take    = 1'b0;
        bit_end = tick && (s_q.sub == 4'(OVS - 1));
        if (tick && s_q.st != LN_IDLE) s_d.sub = s_q.sub + 1'b1;
        case (s_q.st)
            LN_IDLE: begin
                s_d.txd = 1'b1;
                if (have) begin
                    take    = 1'b1;
                    s_d.st  = LN_START;
                    s_d.sub = '0;
                    s_d.sh  = data;
                    s_d.par = (^data) ^ PAR_ODD;
                    s_d.txd = 1'b0;
                end
            end
            LN_START: if (bit_end) begin
                s_d.st  = LN_DATA;
                s_d.idx = '0;
                s_d.txd = s_q.sh[0];
            end
            LN_DATA: if (bit_end) begin
                if (s_q.idx == IW'(DATA_BITS - 1)) begin
                    if (PAR_EN) begin
                        s_d.st  = LN_PAR;
                        s_d.txd = s_q.par;
                    end else begin
                        s_d.st  = LN_STOP;
                        s_d.txd = 1'b1;
                    end
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                    s_d.sh  = s_q.sh >> 1;
                    s_d.txd = s_q.sh[1];
                end
            end
            LN_PAR: if (bit_end) begin
                s_d.st  = LN_STOP;
                s_d.txd = 1'b1;
            end
            LN_STOP: if (bit_end) begin
                s_d.st  = LN_IDLE;
                s_d.txd = 1'b1;
            end
            default: s_d = TX_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= TX_RST;
        else        s_q <= s_d;
    end

    assign txd = s_q.txd;

    AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == LN_STOP) |-> txd); // R3

endmodule

// File: rtl/ser_rx.sv
module ser_rx
    import ser_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter bit PAR_EN    = 1'b1,
    parameter bit PAR_ODD   = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rxd,
    output logic                 valid,
    output logic [DATA_BITS-1:0] data,
    output logic                 ferr,
    output logic                 perr
);
    localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    typedef struct packed {
        line_st_e             st;
        logic [3:0]           sub;
        logic [IW-1:0]        idx;
        logic [DATA_BITS-1:0] sh;
        logic                 par;
        logic                 vld;
        logic                 fe;
        logic                 pe;
    } rx_t;

    localparam rx_t RX_RST = '{st: LN_IDLE, sub: 4'd0, idx: '0, sh: '0,
                               par: 1'b0, vld: 1'b0, fe: 1'b0, pe: 1'b0};

    rx_t  s_q, s_d;
    logic mid_bit;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        s_d.fe  = 1'b0;
        s_d.pe  = 1'b0;
        mid_bit = tick && (s_q.sub == 4'(OVS - 1));
        if (tick && s_q.st != LN_IDLE) s_d.sub = s_q.sub + 1'b1;
        case (s_q.st)
            LN_IDLE: if (tick && !rxd) begin
                s_d.st  = LN_START;
                s_d.sub = '0;
            end
            LN_START: if (tick && s_q.sub == 4'(OVS / 2 - 1)) begin
                if (!rxd) begin
                    s_d.st  = LN_DATA;
                    s_d.sub = '0;
                    s_d.idx = '0;
                    s_d.par = PAR_ODD;
                end else begin
                    s_d.st = LN_IDLE;
                end
            end
            LN_DATA: if (mid_bit) begin
                s_d.sh  = {rxd, s_q.sh[DATA_BITS-1:1]};
                s_d.par = s_q.par ^ rxd;
                if (s_q.idx == IW'(DATA_BITS - 1)) s_d.st = PAR_EN ? LN_PAR : LN_STOP;
                else                               s_d.idx = s_q.idx + 1'b1;
            end
            LN_PAR: if (mid_bit) begin
                s_d.par = s_q.par ^ rxd;
                s_d.st  = LN_STOP;
            end
            LN_STOP: if (mid_bit) begin
                s_d.vld = 1'b1;
                s_d.fe  = !rxd;
                s_d.pe  = PAR_EN && s_q.par;
                s_d.st  = LN_IDLE;
            end
            default: s_d = RX_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RX_RST;
        else        s_q <= s_d;
    end

    assign valid = s_q.vld;
    assign data  = s_q.sh;
    assign ferr  = s_q.fe;
    assign perr  = s_q.pe;

    AST_RX_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R5

endmodule

// File: rtl/ser_port.sv
module ser_port
    import ser_pkg::*;
#(
    parameter int TICK_DIV   = 54,
    parameter int DATA_BITS  = 8,
    parameter bit PAR_EN     = 1'b1,
    parameter bit PAR_ODD    = 1'b0,
    parameter int FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        txd,
    input  logic        rxd
);
    localparam int TDW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [TDW-1:0] tdiv;
        logic           rx_s1;
        logic           rx_s2;
        logic           ie;
        logic           ovr;
        logic           fe;
        logic           pe;
        logic           irq;
        logic           rxne_p;
        logic           txem_p;
    } top_t;

    localparam top_t TOP_RST = '{tdiv: '0, rx_s1: 1'b1, rx_s2: 1'b1, ie: 1'b0,
                                 ovr: 1'b0, fe: 1'b0, pe: 1'b0, irq: 1'b0,
                                 rxne_p: 1'b0, txem_p: 1'b1};

    top_t s_q, s_d;

    logic                 tick;
    logic                 aligned;
    logic                 hit_rx, hit_tx, hit_st, hit_ct;
    logic                 rx_push, rx_pop, rx_clr, rx_empty, rx_full;
    logic                 tx_push, tx_pop, tx_clr, tx_empty, tx_full;
    logic [DATA_BITS-1:0] rx_dout, tx_dout, rx_byte;
    logic                 rx_vld, rx_fe, rx_pe;
    logic [7:0]           stat;
    logic                 unused_hi;

    assign unused_hi = ^bus_wdata[31:DATA_BITS];

    always_comb begin
        s_d     = s_q;
        tick    = (s_q.tdiv == TDW'(TICK_DIV - 1));
        s_d.tdiv = tick ? '0 : s_q.tdiv + 1'b1;
        s_d.rx_s1 = rxd;
        s_d.rx_s2 = s_q.rx_s1;

        aligned = (bus_addr[1:0] == 2'b00);
        hit_rx  = bus_re && aligned && (bus_addr[3:2] == WRD_RXQ);
        hit_tx  = bus_we && aligned && (bus_addr[3:2] == WRD_TXQ);
        hit_st  = bus_re && aligned && (bus_addr[3:2] == WRD_STAT);
        hit_ct  = bus_we && aligned && (bus_addr[3:2] == WRD_CTRL);

        rx_pop  = hit_rx;
        tx_push = hit_tx;
        tx_clr  = hit_ct && bus_wdata[CB_TX_FLUSH];
        rx_clr  = hit_ct && bus_wdata[CB_RX_FLUSH];
        rx_push = rx_vld && !rx_full;

        s_d.ovr = (rx_vld && rx_full) || (s_q.ovr && !hit_st);
        s_d.fe  = (rx_vld && rx_fe)   || (s_q.fe  && !hit_st);
        s_d.pe  = (rx_vld && rx_pe)   || (s_q.pe  && !hit_st);
        if (hit_ct) s_d.ie = bus_wdata[CB_IEN];

        s_d.rxne_p = !rx_empty;
        s_d.txem_p = tx_empty;
        s_d.irq    = s_q.ie && ((!rx_empty && !s_q.rxne_p) ||
                                (tx_empty && !s_q.txem_p));

        stat = {s_q.pe, s_q.fe, s_q.ovr, s_q.ie,
                tx_full, tx_empty, rx_full, !rx_empty};
        rx_byte = rx_empty ? '0 : rx_dout;
        bus_rdata = '0;
        if (aligned) begin
            case (bus_addr[3:2])
                WRD_RXQ:  bus_rdata = 32'(rx_byte);
                WRD_STAT: bus_rdata = {24'd0, stat};
                default:  bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= TOP_RST;
        else        s_q <= s_d;
    end

    assign irq = s_q.irq;

    ser_fifo #(.WIDTH(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .din(rx_dout_in),
        .pop(rx_pop), .dout(rx_dout), .empty(rx_empty), .full(rx_full));

    logic [DATA_BITS-1:0] rx_dout_in;
    ser_rx #(.DATA_BITS(DATA_BITS), .PAR_EN(PAR_EN), .PAR_ODD(PAR_ODD)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(s_q.rx_s2),
        .valid(rx_vld), .data(rx_dout_in), .ferr(rx_fe), .perr(rx_pe));

    ser_fifo #(.WIDTH(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push),
        .din(bus_wdata[DATA_BITS-1:0]), .pop(tx_pop), .dout(tx_dout),
        .empty(tx_empty), .full(tx_full));

    ser_tx #(.DATA_BITS(DATA_BITS), .PAR_EN(PAR_EN), .PAR_ODD(PAR_ODD)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .have(!tx_empty), .data(tx_dout),
        .take(tx_pop), .txd(txd));

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(s_q.ie)); // R12
    AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ovr) |-> $past(rx_full)); // R6
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re)); // R2

endmodule

// File: tb/sim_ser_port.sv
module sim_ser_port;
    localparam int CLK_PERIOD = 10;
    localparam int TD    = 2;
    localparam int BIT   = 16 * TD;
    localparam int FRAME = 11 * BIT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        txd;
    logic        rxd = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    ser_port #(.TICK_DIV(TD), .DATA_BITS(8), .PAR_EN(1'b1), .PAR_ODD(1'b0),
               .FIFO_DEPTH(16)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .txd(txd), .rxd(rxd));

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) if (irq === 1'b1) irq_cnt <= irq_cnt + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b, input bit bad_stop, input bit bad_par);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BIT) @(negedge clk);
        end
        rxd = (^b) ^ bad_par;
        repeat (BIT) @(negedge clk);
        if (bad_stop) begin
            rxd = 1'b0;
            repeat (BIT * 3 / 4) @(negedge clk);
            rxd = 1'b1;
            repeat (BIT / 4) @(negedge clk);
        end else begin
            rxd = 1'b1;
            repeat (BIT) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic grab_tx(output logic [7:0] b, output bit ok);
        logic p;
        while (txd !== 1'b0) @(negedge clk);
        repeat (BIT / 2) @(negedge clk);
        ok = (txd === 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            b[i] = txd;
        end
        repeat (BIT) @(negedge clk);
        p = txd;
        ok = ok && (p === ^b);
        repeat (BIT) @(negedge clk);
        ok = ok && (txd === 1'b1);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  b;
        bit          ok;
        bit          saw;
        int          c0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        bus_rd(4'h8, d); chk("R1 status", d, 32'h04);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 txd", 32'(txd), 1);
        // R2 write-only / push-only words read zero
        bus_rd(4'h4, d); chk("R2 read 0x4", d, 0);
        bus_rd(4'hC, d); chk("R2 read 0xC", d, 0);

        // R5 R2 receive sweep over byte values
        for (int v = 0; v < 256; v += 5) begin
            send_frame(8'(v), 1'b0, 1'b0);
            bus_rd(4'h8, d); chk("R5 status after rx", d, 32'h05);
            bus_rd(4'h0, d); chk("R2 R5 rx byte", d, 32'(v));
        end
        bus_rd(4'h8, d); chk("R5 drained", d, 32'h04);

        // R6 overrun: fill then one extra
        for (int k = 0; k < 16; k++) send_frame(pat(k), 1'b0, 1'b0);
        bus_rd(4'h8, d); chk("R5 rx full", d, 32'h07);
        send_frame(8'hEE, 1'b0, 1'b0);
        bus_rd(4'h8, d); chk("R6 overrun flag", d, 32'h27);
        bus_rd(4'h8, d); chk("R9 cleared on read", d, 32'h07);
        for (int k = 0; k < 16; k++) begin
            bus_rd(4'h0, d); chk("R6 R5 order kept, extra dropped", d, 32'(pat(k)));
        end
        bus_rd(4'h8, d); chk("R6 empty after drain", d, 32'h04);

        // R7 framing
        send_frame(8'h3C, 1'b1, 1'b0);
        bus_rd(4'h8, d); chk("R7 framing flag", d, 32'h45);
        bus_rd(4'h8, d); chk("R9 framing cleared", d, 32'h05);
        bus_rd(4'h0, d); chk("R7 byte kept", d, 32'h3C);

        // R8 parity
        send_frame(8'hC1, 1'b0, 1'b1);
        bus_rd(4'h8, d); chk("R8 parity flag", d, 32'h85);
        bus_rd(4'h8, d); chk("R9 parity cleared", d, 32'h05);
        bus_rd(4'h0, d); chk("R8 byte kept", d, 32'hC1);

        // R10 receive flush, self-clearing
        send_frame(8'h11, 1'b0, 1'b0);
        send_frame(8'h22, 1'b0, 1'b0);
        bus_wr(4'hC, 32'h02);
        bus_rd(4'h8, d); chk("R10 rx flush", d, 32'h04);
        send_frame(8'h33, 1'b0, 1'b0);
        bus_wr(4'hC, 32'h00);
        bus_rd(4'h8, d); chk("R10 flush bit not stored", d, 32'h05);
        bus_rd(4'h0, d); chk("R10 byte survives", d, 32'h33);

        // R3 transmit sweep
        for (int k = 0; k < 6; k++) begin
            logic [7:0] v;
            v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h55 :
                (k == 3) ? 8'hA5 : (k == 4) ? 8'h01 : 8'h80;
            bus_wr(4'h4, 32'(v));
            grab_tx(b, ok);
            chk("R3 tx byte", 32'(b), 32'(v));
            chk("R3 tx framing and parity", 32'(ok), 1);
        end

        // R4 burst of 20 writes: 17 accepted, rest dropped
        fork
            begin
                @(negedge clk);
                bus_addr = 4'h4; bus_we = 1'b1;
                for (int i = 0; i < 20; i++) begin
                    bus_wdata = 32'(pat(i + 40));
                    @(negedge clk);
                end
                bus_we = 1'b0;
                bus_rd(4'h8, d); chk("R4 tx full flag", d, 32'h08);
            end
            begin
                for (int k = 0; k < 17; k++) begin
                    grab_tx(b, ok);
                    chk("R4 R3 queued byte", 32'(b), 32'(pat(k + 40)));
                    chk("R3 burst frame ok", 32'(ok), 1);
                end
            end
        join
        saw = 1'b0;
        repeat (3 * FRAME) begin
            @(negedge clk);
            if (txd !== 1'b1) saw = 1'b1;
        end
        chk("R4 dropped writes not sent", 32'(saw), 0);
        bus_rd(4'h8, d); chk("R4 tx empty", d, 32'h04);

        // R10 transmit flush keeps frame in flight
        for (int i = 0; i < 5; i++) bus_wr(4'h4, 32'(pat(i + 90)));
        bus_wr(4'hC, 32'h01);
        bus_rd(4'h8, d); chk("R10 tx flush", d, 32'h04);
        grab_tx(b, ok);
        chk("R10 in-flight frame finished", 32'(b), 32'(pat(90)));
        saw = 1'b0;
        repeat (2 * FRAME) begin
            @(negedge clk);
            if (txd !== 1'b1) saw = 1'b1;
        end
        chk("R10 flushed bytes not sent", 32'(saw), 0);

        // R11 R12 interrupt
        bus_wr(4'hC, 32'h10);
        bus_rd(4'h8, d); chk("R11 enable visible", d, 32'h14);
        c0 = irq_cnt;
        send_frame(8'h5A, 1'b0, 1'b0);
        chk("R12 rx arrival pulse", 32'(irq_cnt - c0), 1);
        bus_rd(4'h0, d); chk("R12 rx byte", d, 32'h5A);
        repeat (4) @(negedge clk);
        chk("R12 no pulse on drain", 32'(irq_cnt - c0), 1);
        bus_wr(4'h4, 32'h77);
        repeat (4) @(negedge clk);
        chk("R12 tx empty pulse", 32'(irq_cnt - c0), 2);
        grab_tx(b, ok);
        chk("R12 tx byte", 32'(b), 32'h77);
        bus_wr(4'hC, 32'h00);
        bus_rd(4'h8, d); chk("R11 enable off", d, 32'h04);
        send_frame(8'h66, 1'b0, 1'b0);
        bus_wr(4'h4, 32'h44);
        grab_tx(b, ok);
        chk("R12 silent when disabled", 32'(irq_cnt - c0), 2);
        bus_rd(4'h0, d); chk("R5 last rx byte", d, 32'h66);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule